// File: doc/BRIEF.md
# PHY Link Integrity Monitor

This block decides whether a 10/100 Ethernet PHY link is usable. At 100 Mb/s it watches the data-valid indication from the receive signal processor. With auto-negotiation on, that indication must hold for a stabilization interval of at least 330 µs. The monitor then parks in a ready state until the auto-negotiation block gives its go-ahead, and only then declares the link up. With auto-negotiation off, it declares the link up as soon as data-valid is seen. At 10 Mb/s the decision comes from the 10BASE-T receiver's own link input, and this block only routes it.

The two results are merged into one link status, which drives the link LED and a register-facing status bit. That bit latches low on any loss of link and takes the live value again only when management reads it. The transmit and receive enables are granted only while the 100 Mb/s machine is in its up state. The stabilization interval is a cycle count computed from the clock frequency and the wait time, both given as parameters.

Top module: `phy_link_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the 100 Mb/s machine is in the down state and link_status, link_led, link_status_reg, tx_en and rx_en are all 0.
- R2: With speed_100=1 and an_enable=1, the machine moves from down to ready only after data_valid has been sampled high on SETTLE_CYC consecutive rising edges. SETTLE_CYC is the clock rate in kHz times the wait in µs divided by 1000, rounded up. Any low sample restarts the count from zero.
- R3: In the ready state the machine stays there while an_link_ok is 0, and moves to up on the edge where an_link_ok is sampled 1 with data_valid still high.
- R4: With an_enable=0 and speed_100=1, the machine moves from down to up on the first edge where data_valid is sampled high, with no waiting interval.
- R5: Whenever data_valid is 0 in 100 Mb/s mode, link_status is 0 in that same cycle. At the next edge the machine returns to down and the settle count is cleared.
- R6: tx_en and rx_en are 1 exactly in the cycles where the 100 Mb/s machine is in the up state.
- R7: link_led always equals link_status. With speed_100=1, link_status is 1 when the machine is up and data_valid is 1. With speed_100=0, link_status equals link10_in.
- R8: Any change of speed_100 between two sampled edges forces the 100 Mb/s machine to down at that edge. With speed_100=0 the machine stays in down.
- R9: An edge at which link_status is 0 and mgmt_rd is 0 leaves link_status_reg at 0. Once cleared, the bit stays 0 without a read even when the link returns.
- R10: An edge at which mgmt_rd is 1 loads link_status_reg with the value link_status had just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1 selects 100 Mb/s mode, 0 selects 10 Mb/s mode |
| data_valid | input | 1 | Valid receive waveform present (100 Mb/s) |
| an_enable | input | 1 | Auto-negotiation enabled |
| an_link_ok | input | 1 | Go-ahead from the auto-negotiation block |
| link10_in | input | 1 | Link indication from the 10BASE-T receiver |
| mgmt_rd | input | 1 | One-cycle strobe: management reads the status bit |
| link_status | output | 1 | Merged live link status |
| link_status_reg | output | 1 | Latched-low link status bit for the management register |
| link_led | output | 1 | Link LED drive |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |

## Verification
The assertions assume that every input is synchronous to clk and settled before each rising edge. They also assume that mgmt_rd is a strobe whose sampled value is the only thing that matters, and that speed_100 can change on any cycle. The stimulus meets these assumptions by driving every input only at falling edges, from a single process. It runs the machine with the wait shortened to 1 µs, so the stabilization boundary is reached in 125 cycles. A random tail toggles data_valid, the handshake, the mode and the read strobe while staying inside those assumptions.

// File: rtl/link_mon_pkg.sv
`timescale 1ns/1ps
package link_mon_pkg;

  typedef enum logic [1:0] {
    LNK_DOWN  = 2'd0,
    LNK_READY = 2'd1,
    LNK_UP    = 2'd2
  } lnk_state_e;

  // cycles of stable data-valid needed: ceil(kHz * us / 1000), minimum 1
  function automatic int unsigned settle_cycles(input int unsigned clk_khz,
                                                input int unsigned wait_us);
    int unsigned c;
    c = (clk_khz * wait_us + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/link_settle_timer.sv
`timescale 1ns/1ps
module link_settle_timer #(
  parameter int unsigned SETTLE_CYC = 41250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (done)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // R5
  cnt_clear_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/link_fsm.sv
`timescale 1ns/1ps
module link_fsm
  import link_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100,
  input  logic       data_valid,
  input  logic       an_enable,
  input  logic       an_link_ok,
  input  logic       settle_done,
  output logic       settle_run,
  output logic       mode_chg,
  output logic       in_ready,
  output logic       in_up
);
  lnk_state_e state_q, state_d;
  logic       spd_q;

  assign mode_chg   = (speed_100 != spd_q);
  assign in_ready   = (state_q == LNK_READY);
  assign in_up      = (state_q == LNK_UP);
  assign settle_run = (state_q == LNK_DOWN) && speed_100 && data_valid &&
                      an_enable && !mode_chg;

  always_comb begin
    state_d = state_q;
    if (mode_chg || !speed_100 || !data_valid) begin
      state_d = LNK_DOWN;
    end else begin
      unique case (state_q)
        LNK_DOWN:  if (!an_enable)      state_d = LNK_UP;
                   else if (settle_done) state_d = LNK_READY;
        LNK_READY: if (an_link_ok)      state_d = LNK_UP;
        LNK_UP:    state_d = LNK_UP;
        default:   state_d = LNK_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LNK_DOWN;
      spd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      spd_q   <= speed_100;
    end
  end

  // R2
  ready_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(settle_done));

  // R3
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !an_link_ok) |=> !in_up);

  // R4
  an_off_direct_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !in_up && !an_enable && data_valid && speed_100 && !mode_chg)
      |=> in_up);

  // R6
  up_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_up) |-> $past(data_valid && speed_100));

  // R5
  drop_to_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |=> (!in_up && !in_ready));

endmodule

// File: rtl/link_status_latch.sv
`timescale 1ns/1ps
module link_status_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic rd,
  output logic reg_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_bit <= 1'b0;
    else if (rd)    reg_bit <= live;
    else if (!live) reg_bit <= 1'b0;
  end

  // R9
  latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && !rd) |=> !reg_bit);

  // R10
  read_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (reg_bit == $past(live)));

endmodule

// File: rtl/phy_link_monitor.sv
`timescale 1ns/1ps
module phy_link_monitor
  import link_mon_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 125000,
  parameter int unsigned WAIT_US = 330
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_100,
  input  logic data_valid,
  input  logic an_enable,
  input  logic an_link_ok,
  input  logic link10_in,
  input  logic mgmt_rd,
  output logic link_status,
  output logic link_status_reg,
  output logic link_led,
  output logic tx_en,
  output logic rx_en
);
  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_KHZ, WAIT_US);

  logic settle_run, settle_done, mode_chg, in_ready, in_up;
  logic link100;

  link_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (settle_run),
    .done  (settle_done)
  );

  link_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .speed_100   (speed_100),
    .data_valid  (data_valid),
    .an_enable   (an_enable),
    .an_link_ok  (an_link_ok),
    .settle_done (settle_done),
    .settle_run  (settle_run),
    .mode_chg    (mode_chg),
    .in_ready    (in_ready),
    .in_up       (in_up)
  );

  assign link100     = in_up && data_valid;
  assign link_status = rst_n && (speed_100 ? link100 : link10_in);
  assign link_led    = link_status;
  assign tx_en       = in_up;
  assign rx_en       = in_up;

  link_status_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .live    (link_status),
    .rd      (mgmt_rd),
    .reg_bit (link_status_reg)
  );

  // R5
  drop_kills_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_100 && !data_valid) |-> !link_status);

  // R8
  mode_change_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !tx_en);

  // R6
  enables_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en == rx_en);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!tx_en && !link_status && !link_status_reg));

endmodule

// File: tb/test_phy_link_monitor.sv
`timescale 1ns/1ps
module test_phy_link_monitor;

  localparam int CLK_KHZ = 125000;
  localparam int WAIT_US = 1;
  localparam int N_SET   = (CLK_KHZ * WAIT_US + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_100 = 1'b1, data_valid = 1'b0, an_enable = 1'b1;
  logic an_link_ok = 1'b0, link10_in = 1'b0, mgmt_rd = 1'b0;
  logic link_status, link_status_reg, link_led, tx_en, rx_en;

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 1'b0;
  string phase = "R1";

  // reference state: 0 down, 1 ready, 2 up
  int rs = 0, rcnt = 0;
  bit rspd = 1'b0, rreg = 1'b0;

  always #4 clk = ~clk;

  phy_link_monitor #(.CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US)) i_phy_link_monitor (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .data_valid(data_valid),
    .an_enable(an_enable), .an_link_ok(an_link_ok), .link10_in(link10_in),
    .mgmt_rd(mgmt_rd), .link_status(link_status), .link_status_reg(link_status_reg),
    .link_led(link_led), .tx_en(tx_en), .rx_en(rx_en)
  );

  function automatic bit live_exp();
    if (!rst_n) return 1'b0;
    if (speed_100) return (rs == 2) && data_valid;
    return link10_in;
  endfunction

  always @(posedge clk) begin
    bit live, chg;
    live = live_exp();
    if (!rst_n) begin
      rs = 0; rcnt = 0; rspd = 1'b0; rreg = 1'b0;
    end else begin
      if (mgmt_rd) rreg = live;
      else if (!live) rreg = 1'b0;
      chg  = (speed_100 != rspd);
      rspd = speed_100;
      if (chg || !speed_100 || !data_valid) begin
        rs = 0; rcnt = 0;
      end else if (rs == 0) begin
        if (!an_enable) begin rs = 2; rcnt = 0; end
        else if (rcnt == N_SET - 1) begin rs = 1; rcnt = 0; end
        else rcnt = rcnt + 1;
      end else if (rs == 1) begin
        if (an_link_ok) rs = 2;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s at %0t: actual=%b expected=%b", req, phase, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (!finished) begin
      chk("R7", "link_status", link_status, live_exp());
      chk("R7", "link_led", link_led, live_exp());
      chk("R6", "tx_en", tx_en, rst_n && rs == 2);
      chk("R6", "rx_en", rx_en, rst_n && rs == 2);
      chk("R9", "link_status_reg", link_status_reg, rst_n && rreg);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(1);
    // R1: outputs quiet in reset and just after
    phase = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R2: settle count, interrupted once, then full
    phase = "R2";
    data_valid = 1'b1; cyc(60);
    data_valid = 1'b0; cyc(1);
    data_valid = 1'b1; cyc(N_SET + 5);
    // R3: ready waits for the go-ahead
    phase = "R3";
    cyc(5);
    an_link_ok = 1'b1; cyc(3);
    an_link_ok = 1'b0; cyc(4);
    // R10: read loads the live value
    phase = "R10";
    mgmt_rd = 1'b1; cyc(1);
    mgmt_rd = 1'b0; cyc(3);
    // R5 / R9: drop, latch low, link returns without read
    phase = "R5";
    data_valid = 1'b0; cyc(1);
    data_valid = 1'b1;
    phase = "R4";
    an_enable = 1'b0; cyc(1);
    cyc(4);
    phase = "R9";
    cyc(3);
    mgmt_rd = 1'b1; cyc(1);
    mgmt_rd = 1'b0; cyc(2);
    // R8: switch to 10 Mb/s, follow link10_in, switch back
    phase = "R8";
    speed_100 = 1'b0; cyc(2);
    link10_in = 1'b1; cyc(3);
    link10_in = 1'b0; cyc(2);
    link10_in = 1'b1; mgmt_rd = 1'b1; cyc(1);
    mgmt_rd = 1'b0; cyc(2);
    speed_100 = 1'b1; cyc(4);
    speed_100 = 1'b0; cyc(1);
    speed_100 = 1'b1; an_enable = 1'b1; cyc(N_SET + 3);
    an_link_ok = 1'b1; cyc(3);
    // R5: random tail
    phase = "R5";
    for (int i = 0; i < 3000; i++) begin
      data_valid = ($urandom_range(0, 199) != 0);
      an_link_ok = ($urandom_range(0, 9) == 0);
      mgmt_rd    = ($urandom_range(0, 15) == 0);
      link10_in  = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 999) == 0) speed_100 = ~speed_100;
      if ($urandom_range(0, 499) == 0) an_enable = ~an_enable;
      cyc(1);
    end
    cyc(2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule